// File: doc/BRIEF.md
# Locked Extended Display-Controller Register Bank

This block holds the extended registers of a display controller that software reaches through an 8-bit index/data port pair. A write to the index port selects a register, and a write to the data port updates the selected register. The port pair has two possible bases. One input, taken from the miscellaneous-output register, chooses between them. Accesses at the base that is not selected are ignored.

Three register groups live in the bank:
- A key register guards a 32-bit configuration strap word. Software builds the strap word one byte at a time, and each byte write is accepted only while the key holds its unlock value.
- Two cross-coupled registers drive fields into the display logic: bit 8 of the display row offset, bits 19:18 of the latched start address, and bits 5:4 of the write bank.
- The index latch itself.

A read returns the stored value combinationally. A write reaches its outputs at the next clock edge.

Top module: `crtc_ext_bank`

## Requirements
- R1: The port base is 0x3D0 when `color_sel` is 1 and 0x3B0 when it is 0. The index port is at base+4 and the data port at base+5. Writes to any other address, including the ports of the base that is not selected, change nothing.
- R2: A write to the index port only latches the 8-bit index. A read of the index port returns the latched index.
- R3: The key register is at index 0x39. A strap byte write takes effect only if the key holds 0xA5 at the moment of the write. Otherwise the write is discarded.
- R4: Strap bytes map as follows: index 0x36 loads `strap_word[7:0]`, 0x37 loads [15:8], 0x68 loads [23:16], and 0x6F loads [31:24].
- R5: A write to index 0x43 stores the full byte. Its bit 2 is copied to `offset_b8` only when bits 5:4 of the stored index-0x51 register are both 0 at the time of the write. Otherwise `offset_b8` keeps its value.
- R6: A write to index 0x51 stores the byte and loads data bits 1:0 into `start_hi` (start-address bits 19:18).
- R7: A write to index 0x51 loads data bits 3:2 into `bank_hi` (write-bank bits 5:4).
- R8: A read of the data port returns the stored byte for indexes 0x36, 0x37, 0x68, 0x6F, 0x39, 0x43 and 0x51, and 0x00 for any other index. Any address other than the two selected ports reads 0x00.
- R9: Reset (synchronous, active low) clears every register, including the key. Strap writes therefore stay blocked until the key is written.
- R10: The result of a data-port write is visible on the outputs and in readback in the cycle after the write edge. Read data depends combinationally on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| color_sel | input | 1 | Miscellaneous-output bit 0: selects base 0x3D0 (1) or 0x3B0 (0) |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| strap_word | output | 32 | Configuration strap word |
| offset_b8 | output | 1 | Display offset bit 8 |
| start_hi | output | 2 | Start-address bits 19:18 |
| bank_hi | output | 2 | Write-bank bits 5:4 |

## Verification
Each write is one clocked cycle. Every register is a single flop stage, so any write result is due one edge after the strobe. Read data has no register, so readback is due in the same cycle that the address is presented. The bench drives each access on a falling edge and samples registered outputs on the next falling edge. It samples readback one time unit after setting the address. Every expectation therefore lands in the cycle in which it is due.

// File: rtl/crtc_ext_pkg.sv
// Shared constants for the extended display-controller register bank.
// Assumes 8-bit registers behind an index/data port pair.
package crtc_ext_pkg;
    localparam int          REG_W       = 8;
    localparam int          STRAP_BYTES = 4;
    localparam logic [7:0]  IDX_KEY     = 8'h39;
    localparam logic [7:0]  IDX_PITCH   = 8'h43;
    localparam logic [7:0]  IDX_SYSCFG  = 8'h51;
    localparam logic [7:0]  KEY_UNLOCK  = 8'hA5;
    localparam logic [15:0] BASE_COLOR  = 16'h03D0;
    localparam logic [15:0] BASE_MONO   = 16'h03B0;
    localparam logic [15:0] OFS_INDEX   = 16'h0004;
    localparam logic [15:0] OFS_DATA    = 16'h0005;

    // Index that loads strap lane n (lane 0 = bits 7:0).
    function automatic logic [7:0] strap_lane_idx(input int n);
        case (n)
            0:       return 8'h36;
            1:       return 8'h37;
            2:       return 8'h68;
            default: return 8'h6F;
        endcase
    endfunction
endpackage

// File: rtl/crtc_port_decode.sv
// Decodes the index/data port pair at the selected base and holds the index.
// Assumes writes arrive as single-cycle strobes.
module crtc_port_decode
    import crtc_ext_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          color_sel,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    idx_q,
    output logic          data_we,
    output logic          hit_idx,
    output logic          hit_data
);
    logic [AW-1:0] base;
    logic          idx_we;

    // Pick the port base from the miscellaneous-output bit.
    always_comb base = color_sel ? AW'(BASE_COLOR) : AW'(BASE_MONO);

    // Address match for the two ports.
    always_comb begin
        hit_idx  = (io_addr == base + AW'(OFS_INDEX));
        hit_data = (io_addr == base + AW'(OFS_DATA));
        idx_we   = io_wr && hit_idx;
        data_we  = io_wr && hit_data;
    end

    // Index latch: loaded only by index-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= io_wdata;
    end

    // The index changes only through an index-port write (R2).
    p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == base + AW'(OFS_INDEX)) |=> $stable(idx_q));
endmodule

// File: rtl/crtc_strap_bank.sv
// Key register and the key-guarded strap word, one lane per strap byte.
// Assumes the caller presents a decoded data write and the current index.
module crtc_strap_bank
    import crtc_ext_pkg::*;
#(
    parameter int NLANES = STRAP_BYTES,
    localparam int SW    = NLANES * REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_we,
    input  logic [7:0]    idx,
    input  logic [7:0]    wdata,
    output logic [SW-1:0] strap_word,
    output logic          rd_hit,
    output logic [7:0]    rd_byte
);
    logic [7:0] key_q;
    logic [7:0] lane_q [NLANES];
    logic       unlocked;

    // The key must hold the unlock value for strap writes to land.
    always_comb unlocked = (key_q == KEY_UNLOCK);

    // Key register: written freely.
    always_ff @(posedge clk) begin
        if (!rst_n)                          key_q <= '0;
        else if (data_we && idx == IDX_KEY)  key_q <= wdata;
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        // Strap lane g: written only while unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_q[g] <= '0;
            else if (data_we && unlocked && idx == strap_lane_idx(g))
                lane_q[g] <= wdata;
        end
        assign strap_word[g*REG_W +: REG_W] = lane_q[g];
    end

    // Readback of the key and the strap lanes.
    always_comb begin
        rd_hit  = (idx == IDX_KEY);
        rd_byte = key_q;
        for (int n = 0; n < NLANES; n++) begin
            if (idx == strap_lane_idx(n)) begin
                rd_hit  = 1'b1;
                rd_byte = lane_q[n];
            end
        end
    end

    // While locked, the strap word holds (R3).
    p_strap_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q != KEY_UNLOCK) |=> $stable(strap_word));
    // The strap word changes only after a data write (R4).
    p_strap_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> $stable(strap_word));
endmodule

// File: rtl/crtc_cross_fields.sv
// Row-pitch and system-config registers with their routed display fields.
// Assumes offset bit 8 is gated by the system-config value held at write time.
module crtc_cross_fields
    import crtc_ext_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_we,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic       offset_b8,
    output logic [1:0] start_hi,
    output logic [1:0] bank_hi,
    output logic       rd_hit,
    output logic [7:0] rd_byte
);
    logic [7:0] pitch_q;
    logic [7:0] syscfg_q;
    logic       pitch_we;
    logic       sys_we;
    logic       route_ok;

    // Write enables and the routing gate.
    always_comb begin
        pitch_we = data_we && (idx == IDX_PITCH);
        sys_we   = data_we && (idx == IDX_SYSCFG);
        route_ok = (syscfg_q[5:4] == 2'b00);
    end

    // Row-pitch register and the gated offset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pitch_q   <= '0;
            offset_b8 <= 1'b0;
        end else if (pitch_we) begin
            pitch_q <= wdata;
            if (route_ok) offset_b8 <= wdata[2];
        end
    end

    // System-config register and its start-address and bank fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syscfg_q <= '0;
            start_hi <= '0;
            bank_hi  <= '0;
        end else if (sys_we) begin
            syscfg_q <= wdata;
            start_hi <= wdata[1:0];
            bank_hi  <= wdata[3:2];
        end
    end

    // Readback.
    always_comb begin
        rd_hit  = (idx == IDX_PITCH) || (idx == IDX_SYSCFG);
        rd_byte = (idx == IDX_PITCH) ? pitch_q : syscfg_q;
    end

    p_offset_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && idx == IDX_PITCH && syscfg_q[5:4] != 2'b00) |=> $stable(offset_b8));
    p_start_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && idx == IDX_SYSCFG) |=> (start_hi == $past(wdata[1:0])));
    p_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && idx == IDX_SYSCFG) |=> (bank_hi == $past(wdata[3:2])));
endmodule

// File: rtl/crtc_ext_bank.sv
// Top of the extended register bank: port decode, strap bank, cross fields
// and the readback mux. Read data is combinational on the address.
module crtc_ext_bank
    import crtc_ext_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          color_sel,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    output logic [31:0]   strap_word,
    output logic          offset_b8,
    output logic [1:0]    start_hi,
    output logic [1:0]    bank_hi
);
    logic [7:0] idx_q;
    logic       data_we, hit_idx, hit_data;
    logic       strap_hit, cross_hit;
    logic [7:0] strap_rd, cross_rd;

    crtc_port_decode #(.AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .color_sel(color_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_wdata(io_wdata), .idx_q(idx_q), .data_we(data_we),
        .hit_idx(hit_idx), .hit_data(hit_data)
    );

    crtc_strap_bank #(.NLANES(STRAP_BYTES)) u_strap (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .idx(idx_q),
        .wdata(io_wdata), .strap_word(strap_word), .rd_hit(strap_hit),
        .rd_byte(strap_rd)
    );

    crtc_cross_fields u_cross (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .idx(idx_q),
        .wdata(io_wdata), .offset_b8(offset_b8), .start_hi(start_hi),
        .bank_hi(bank_hi), .rd_hit(cross_hit), .rd_byte(cross_rd)
    );

    // Readback mux: index port, data port by index, otherwise zero (R8).
    always_comb begin
        if (hit_idx)                     io_rdata = idx_q;
        else if (hit_data && strap_hit)  io_rdata = strap_rd;
        else if (hit_data && cross_hit)  io_rdata = cross_rd;
        else                             io_rdata = 8'h00;
    end

    // A write away from the selected ports changes no output (R1).
    p_foreign_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !hit_idx && !hit_data) |=>
            ($stable(strap_word) && $stable(start_hi) && $stable(offset_b8)));
endmodule

// File: tb/crtc_ext_bank_tb.sv
module crtc_ext_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        color_sel = 1'b1;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [31:0] strap_word;
    logic        offset_b8;
    logic [1:0]  start_hi, bank_hi;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    crtc_ext_bank u_dut (
        .clk(clk), .rst_n(rst_n), .color_sel(color_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .strap_word(strap_word), .offset_b8(offset_b8), .start_hi(start_hi),
        .bank_hi(bank_hi)
    );

    // {color, index, data, expected readback}
    localparam int NV = 11;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h36, 8'h11, 8'h00},   // R3 locked after reset
        {1'b1, 8'h39, 8'hA5, 8'hA5},   // R3 key
        {1'b1, 8'h36, 8'h11, 8'h11},   // R4 lane 0
        {1'b0, 8'h37, 8'h22, 8'h22},   // R1 mono base, R4 lane 1
        {1'b1, 8'h68, 8'h33, 8'h33},   // R4 lane 2
        {1'b1, 8'h6F, 8'h44, 8'h44},   // R4 lane 3
        {1'b1, 8'h51, 8'h0F, 8'h0F},   // R6 R7
        {1'b1, 8'h43, 8'h04, 8'h04},   // R5 routed
        {1'b1, 8'h20, 8'h77, 8'h00},   // R8 unimplemented
        {1'b1, 8'h39, 8'h00, 8'h00},   // R3 relock
        {1'b1, 8'h37, 8'hEE, 8'h22}    // R3 discarded
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] base_of(input logic c);
        return c ? 16'h03D0 : 16'h03B0;
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        io_addr = a;
        #1 d = io_rdata;
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset strap", strap_word, 32'h0);
        check("R9 reset fields", {offset_b8, start_hi, bank_hi}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            color_sel = VEC[i][24];
            wr(base_of(VEC[i][24]) + 16'h4, VEC[i][23:16]);
            wr(base_of(VEC[i][24]) + 16'h5, VEC[i][15:8]);
            rd(base_of(VEC[i][24]) + 16'h5, r);
            check($sformatf("R8 readback vec%0d", i), r, VEC[i][7:0]);
        end
        color_sel = 1'b1;
        check("R4 strap word", strap_word, 32'h44332211);
        check("R5 offset routed", offset_b8, 1'b1);
        check("R6 start bits", start_hi, 2'd3);
        check("R7 bank bits", bank_hi, 2'd3);

        // R2: index port reads back the latched index.
        wr(16'h03D4, 8'h43);
        rd(16'h03D4, r);
        check("R2 index readback", r, 8'h43);

        // R1: writes at the unselected base are ignored.
        wr(16'h03B4, 8'h51);
        wr(16'h03B5, 8'h99);
        rd(16'h03D4, r);
        check("R1 foreign index ignored", r, 8'h43);
        rd(16'h03D5, r);
        check("R1 foreign data ignored", r, 8'h04);
        rd(16'h03B5, r);
        check("R8 unselected port reads zero", r, 8'h00);

        // R5: gate closed when syscfg bits 5:4 are nonzero.
        wr(16'h03D4, 8'h51);
        wr(16'h03D5, 8'h30);
        check("R6 start cleared", start_hi, 2'd0);
        check("R7 bank cleared", bank_hi, 2'd0);
        wr(16'h03D4, 8'h43);
        wr(16'h03D5, 8'h00);
        check("R5 offset held", offset_b8, 1'b1);
        rd(16'h03D5, r);
        check("R5 byte stored", r, 8'h00);

        // R10: output visible in the cycle after the write edge.
        wr(16'h03D4, 8'h51);
        @(negedge clk);
        io_addr = 16'h03D5; io_wdata = 8'h02; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R10 next-cycle update", start_hi, 2'd2);

        // R9: reset clears key; strap writes blocked afterwards.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 strap cleared", strap_word, 32'h0);
        wr(16'h03D4, 8'h39);
        rd(16'h03D5, r);
        check("R9 key cleared", r, 8'h00);
        wr(16'h03D4, 8'h6F);
        wr(16'h03D5, 8'h5A);
        check("R9 strap blocked", strap_word, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule